// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two signed square matrices on an N x N grid of identical multiply-accumulate cells. Each cell keeps one element of the product in its own accumulator. Rows of the left operand stream in from the west edge and move east one cell per clock. Columns of the right operand stream in from the north edge and move south one cell per clock. Each stream is delayed by its row or column index, so that matching operands meet in the cell that owns their product term.

A one-cycle start pulse latches both input matrices and clears the grid. Edge feeders then read each latched element exactly once, on the cycle when its skewed slot comes up, and drive zero in every empty slot. Every result appears at the same time on a flat parallel output. A done flag rises after 3N-2 accumulate cycles and stays high until the next start.

Top module: `systolic_matmul`

## Requirements
- R1: After reset, done_o is low and every result field of c_o is zero.
- R2: Operand matrices are latched on the clock edge that samples start_i high. Changes to a_i or b_i after that edge have no effect on the results. Element (r,k) of a_i is at bits [(r*N+k)*W +: W], and element (k,c) of b_i is at bits [(k*N+c)*W +: W]. Both are two's complement.
- R3: When done_o is high, c_o holds the signed product A*B. Element (r,c) is at bits [(r*N+c)*ACC_W +: ACC_W], where ACC_W = 2*W + clog2(N).
- R4: done_o goes high on exactly the 3N-2nd rising edge after the start edge (the 7th for N=3), and is low before that edge.
- R5: Once done_o is high, it stays high and c_o does not change until the next start pulse.
- R6: A start pulse clears done_o on the following edge and restarts the computation from the newly latched operands, even when it arrives during a run or on that run's last accumulate edge.
- R7: The accumulators do not overflow for full-scale operands. With every element of both matrices at -128 and N=3, each result is 49152.
- R8: [[3,4,2],[2,5,3],[3,2,5]] multiplied by itself gives [[23,36,28],[25,39,34],[28,32,37]].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch operands, clear the grid and begin a run |
| a_i | input | N*N*W | Left operand matrix, row-major |
| b_i | input | N*N*W | Right operand matrix, row-major |
| done_o | output | 1 | Result valid; held until the next start |
| c_o | output | N*N*ACC_W | Product matrix, row-major |

## Verification
Two events can fall in the same cycle: a new start and the final accumulate edge of a run that is still in progress. The bench provokes this by raising start_i exactly on the 3N-2nd edge of a run. On that edge the start must win: done_o must remain low, and after 3N-2 further edges c_o must match the product of the second operand pair, with nothing left over from the first. A restart in the middle of a run is judged in the same way.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;
  function automatic int acc_width(input int w, input int n);
    return 2 * w + $clog2(n);
  endfunction
endpackage

// File: rtl/sysmm_cell.sv
module sysmm_cell #(
  parameter int W  = 8,
  parameter int AW = 18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic signed [W-1:0]  a_i,
  input  logic signed [W-1:0]  b_i,
  output logic signed [W-1:0]  a_o,
  output logic signed [W-1:0]  b_o,
  output logic signed [AW-1:0] acc_o
);
  logic signed [2*W-1:0] prod;
  assign prod = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      a_o   <= '0;
      b_o   <= '0;
    end else if (clr_i) begin
      acc_o <= '0;
      a_o   <= '0;
      b_o   <= '0;
    end else begin
      a_o <= a_i;
      b_o <= b_i;
      if (en_i) acc_o <= acc_o + AW'(prod);
    end
  end

  // R5
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(acc_o));
  // R6
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0));
endmodule

// File: rtl/sysmm_feed.sv
module sysmm_feed #(
  parameter int W   = 8,
  parameter int N   = 3,
  parameter int IDX = 0,
  parameter int CW  = 3
) (
  input  logic [N*W-1:0]      vec_i,
  input  logic [CW-1:0]       tick_i,
  input  logic                busy_i,
  output logic signed [W-1:0] elem_o
);
  // element k leaves this edge feeder on tick k+IDX; empty slots carry zero
  always_comb begin
    int kk;
    kk = int'(tick_i) - IDX;
    elem_o = '0;
    if (busy_i && kk >= 0 && kk < N) elem_o = vec_i[kk*W +: W];
  end
endmodule

// File: rtl/sysmm_ctrl.sv
module sysmm_ctrl #(
  parameter int N  = 3,
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [CW-1:0] tick_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST = CW'(3*N-3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_o <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (start_i) begin
      tick_o <= '0;
      busy_o <= 1'b1;
      done_o <= 1'b0;
    end else if (busy_o) begin
      tick_o <= tick_o + 1'b1;
      if (tick_o == LAST) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  // R4
  tick_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (tick_o <= LAST));
  // R4
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(tick_o) == LAST && $past(busy_o)));
  // R5
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  // R6
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && busy_o));
endmodule

// File: rtl/systolic_matmul.sv
module systolic_matmul #(
  parameter int N  = 3,
  parameter int W  = 8,
  parameter int AW = sysmm_pkg::acc_width(W, N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N*N*W-1:0]  a_i,
  input  logic [N*N*W-1:0]  b_i,
  output logic              done_o,
  output logic [N*N*AW-1:0] c_o
);
  localparam int CW = $clog2(3*N-1);

  logic [N*N*W-1:0] a_q, b_q;
  logic [CW-1:0]    tick;
  logic             busy;

  logic signed [W-1:0]  a_h [N][N+1];
  logic signed [W-1:0]  b_v [N+1][N];
  logic signed [AW-1:0] acc [N][N];
  logic [N*W-1:0]       arow [N];
  logic [N*W-1:0]       bcol [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (start_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  sysmm_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .tick_o(tick), .busy_o(busy), .done_o(done_o)
  );

  for (genvar x = 0; x < N; x++) begin : g_edge
    for (genvar k = 0; k < N; k++) begin : g_pack
      assign arow[x][k*W +: W] = a_q[(x*N+k)*W +: W];
      assign bcol[x][k*W +: W] = b_q[(k*N+x)*W +: W];
    end
    sysmm_feed #(.W(W), .N(N), .IDX(x), .CW(CW)) u_west (
      .vec_i(arow[x]), .tick_i(tick), .busy_i(busy), .elem_o(a_h[x][0])
    );
    sysmm_feed #(.W(W), .N(N), .IDX(x), .CW(CW)) u_north (
      .vec_i(bcol[x]), .tick_i(tick), .busy_i(busy), .elem_o(b_v[0][x])
    );
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      sysmm_cell #(.W(W), .AW(AW)) u_cell (
        .clk_i, .rst_ni,
        .clr_i(start_i), .en_i(busy),
        .a_i(a_h[r][c]),   .b_i(b_v[r][c]),
        .a_o(a_h[r][c+1]), .b_o(b_v[r+1][c]),
        .acc_o(acc[r][c])
      );
      assign c_o[(r*N+c)*AW +: AW] = acc[r][c];
    end
  end

  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(c_o));
endmodule

// File: tb/systolic_matmul_test.sv
module systolic_matmul_test;
  localparam int N  = 3;
  localparam int W  = 8;
  localparam int AW = 2*W + $clog2(N);
  localparam int LAT = 3*N - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N*N*W-1:0]  a = '0, b = '0;
  logic done;
  logic [N*N*AW-1:0] c;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  systolic_matmul #(.N(N), .W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .b_i(b), .done_o(done), .c_o(c)
  );

  function automatic logic [N*N*AW-1:0] ref_mul(input logic [N*N*W-1:0] x,
                                                input logic [N*N*W-1:0] y);
    logic [N*N*AW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int s;
        s = 0;
        for (int k = 0; k < N; k++)
          s += int'($signed(x[(i*N+k)*W +: W])) * int'($signed(y[(k*N+j)*W +: W]));
        r[(i*N+j)*AW +: AW] = AW'(s);
      end
    return r;
  endfunction

  function automatic logic [N*N*W-1:0] rand_mat();
    logic [N*N*W-1:0] m;
    for (int i = 0; i < N*N; i++) m[i*W +: W] = W'($urandom);
    return m;
  endfunction

  function automatic logic [N*N*W-1:0] fill_mat(input int v);
    logic [N*N*W-1:0] m;
    for (int i = 0; i < N*N; i++) m[i*W +: W] = W'(v);
    return m;
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_mat(input string req, input logic [N*N*AW-1:0] exp);
    for (int i = 0; i < N*N; i++) begin
      n_chk++;
      if (c[i*AW +: AW] !== exp[i*AW +: AW]) begin
        n_bad++;
        $display("FAIL %s: element %0d got %0d expected %0d", req, i,
                 $signed(c[i*AW +: AW]), $signed(exp[i*AW +: AW]));
      end
    end
  endtask

  task automatic pulse(input logic [N*N*W-1:0] x, input logic [N*N*W-1:0] y);
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_and_check(input string req, input logic [N*N*W-1:0] x,
                               input logic [N*N*W-1:0] y);
    pulse(x, y);
    repeat (LAT) @(negedge clk);
    chk_bit({req, " done"}, done, 1'b1);
    chk_mat(req, ref_mul(x, y));
  endtask

  initial begin
    logic [N*N*W-1:0] ex, x2, y2;
    void'($urandom(32'h1a2b3c));
    ex = '0;
    ex[0*W +: W] = 8'd3; ex[1*W +: W] = 8'd4; ex[2*W +: W] = 8'd2;
    ex[3*W +: W] = 8'd2; ex[4*W +: W] = 8'd5; ex[5*W +: W] = 8'd3;
    ex[6*W +: W] = 8'd3; ex[7*W +: W] = 8'd2; ex[8*W +: W] = 8'd5;

    repeat (3) @(negedge clk);
    // R1
    chk_bit("R1 done", done, 1'b0);
    chk_mat("R1", '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 exact latency
    pulse(ex, ex);
    repeat (LAT-1) @(negedge clk);
    chk_bit("R4 early", done, 1'b0);
    @(negedge clk);
    chk_bit("R4 on time", done, 1'b1);
    // R8 fixed example
    begin
      logic [N*N*AW-1:0] e8;
      int v[9] = '{23, 36, 28, 25, 39, 34, 28, 32, 37};
      for (int i = 0; i < 9; i++) e8[i*AW +: AW] = AW'(v[i]);
      chk_mat("R8", e8);
    end
    // R5 hold
    a = rand_mat(); b = rand_mat();
    repeat (5) @(negedge clk);
    chk_bit("R5 done", done, 1'b1);
    chk_mat("R5", ref_mul(ex, ex));

    // R7 full-scale negative
    begin
      logic [N*N*AW-1:0] e7;
      for (int i = 0; i < N*N; i++) e7[i*AW +: AW] = AW'(49152);
      pulse(fill_mat(-128), fill_mat(-128));
      repeat (LAT) @(negedge clk);
      chk_mat("R7", e7);
    end
    run_and_check("R7 mixed", fill_mat(127), fill_mat(-128));

    // R2 inputs changed after the start edge are ignored
    x2 = rand_mat(); y2 = rand_mat();
    pulse(x2, y2);
    a = rand_mat(); b = rand_mat();
    repeat (LAT) @(negedge clk);
    chk_mat("R2", ref_mul(x2, y2));

    // R6 start clears done, mid-run restart
    pulse(rand_mat(), rand_mat());
    chk_bit("R6 clear", done, 1'b0);
    repeat (2) @(negedge clk);
    x2 = rand_mat(); y2 = rand_mat();
    run_and_check("R6 midrun", x2, y2);

    // R6 start on the final accumulate edge of a run
    pulse(rand_mat(), rand_mat());
    repeat (LAT-2) @(negedge clk);
    x2 = rand_mat(); y2 = rand_mat();
    pulse(x2, y2);
    chk_bit("R6 collide", done, 1'b0);
    repeat (LAT-1) @(negedge clk);
    chk_bit("R6 collide early", done, 1'b0);
    @(negedge clk);
    chk_bit("R6 collide done", done, 1'b1);
    chk_mat("R6 collide", ref_mul(x2, y2));

    // R3 random products
    for (int t = 0; t < 20; t++) run_and_check("R3", rand_mat(), rand_mat());

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule